// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus-interface state machine of a 16-bit processor with a 20-bit address space and a shared address/data bus. A requester presents one transfer at a time: a word address, a memory-or-I/O select, a direction, byte-lane enables and write data. The sequencer then steps through the fixed bus states T1, T2, optional wait states, T3 and T4. It drives the shared lines and their output enable, the address latch strobe, separate read and write strobes, the space select, the direction line, the data-buffer enable and the active-low upper-lane enable.

The slow side stretches a cycle by holding READY low. Read data is captured from the shared lines at the end of T3. It is returned together with a one-clock `done` pulse in T4, after which the sequencer goes idle and can accept the next request. The upper four address lines carry address in T1 and a small status code in the later states.

Top module: `mux_bus_seq`

## Requirements
- R1: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, and an accepted request starts T1 on the next clock.
- R2: In T1, `ale`=1 and `ad_oe`=1. `ad_out[15:1]` carries address bits 15..1, and `a_hi` carries address bits 19..16. `m_io`=`req_mem` (1 selects memory), `dt_r`=`req_write` (1 means transmit), and `rd_n`, `wr_n` and `den_n` are all 1.
- R3: In T2, in every wait state and in T3, `ale`=0 and `den_n`=0. A read drives `rd_n`=0, `wr_n`=1 and `ad_oe`=0. A write drives `wr_n`=0, `rd_n`=1, `ad_oe`=1 and `ad_out` equal to the write data. `rd_n` and `wr_n` are never low together.
- R4: READY (`ready_in`) is sampled at the end of T2 and at the end of each wait state, and each low sample adds exactly one wait state before T3. Its value during T1 and T3 has no effect.
- R5: `ad_in` is captured at the end of T3 for reads. In T4, `rdata` holds that value and `done` is 1 for exactly one clock. `done` is also given for writes.
- R6: After T1 and until the cycle ends, `a_hi` shows the status code {0, 0, memory select, write}, with the write flag in bit 0.
- R7: `bhe_n` equals the inverse of `req_be[1]` (the upper lane) from T1 to T4. In T1, `ad_out[0]` equals the inverse of `req_be[0]` (the lower lane), so a transfer may be low byte only (be=01), high byte only (be=10) or the full word (be=11).
- R8: In T4, `rd_n`, `wr_n` and `den_n` are 1, `ad_oe`=0, and `m_io` and `dt_r` keep their cycle values. The next clock returns the sequencer to idle.
- R9: While a cycle is in progress, changes on `req_valid` and the request fields have no effect. The cycle completes with the fields latched at acceptance.
- R10: Driving `rst_n` low returns the sequencer to idle at once, even in the middle of a cycle.
- R11: While idle, `ale`=0, `rd_n`=`wr_n`=`den_n`=`bhe_n`=1, `ad_oe`=0, `m_io`=0, `dt_r`=1, `a_hi`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 19 | Address bits 19..1 |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables, bit 1 = upper lane |
| req_wdata | input | 16 | Write data |
| ready_in | input | 1 | READY from the addressed device |
| ad_in | input | 16 | Shared lines as seen from the pins |
| ad_out | output | 16 | Value driven onto the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| a_hi | output | 4 | Upper address in T1, status afterwards |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | Space select, 1 = memory |
| dt_r | output | 1 | Direction, 1 = transmit |
| den_n | output | 1 | Data buffer enable, active low |
| bhe_n | output | 1 | Upper-lane enable, active low |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Captured read data |

## Verification
The assertions assume that READY is a clean synchronous level. They also assume that every request carries at least one byte enable, and that the requester changes nothing in a way that relies on being seen mid-cycle. The stimulus drives every input at the falling clock edge, and it uses only the enable codes 01, 10 and 11. Garbage and decoy requests are applied during a cycle only where R4 and R9 say they must be ignored, and the bench drives `ad_in` with the expected read value only during T3, so a capture in the wrong state shows up as a mismatch.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5
  } bus_state_e;
endpackage

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       ready_in,
  output bus_state_e state,
  output logic       accept
);
  bus_state_e state_q, state_d;

  assign accept = (state_q == ST_IDLE) && req_valid;

  // next-state process
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ready_in ? ST_T3 : ST_TW;
      ST_TW:   state_d = ready_in ? ST_T3 : ST_TW;
      ST_T3:   state_d = ST_T4;
      ST_T4:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/bus_seq_req_reg.sv
module bus_seq_req_reg #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              cap_en,
  input  logic [ADDR_W-1:1] in_addr,
  input  logic              in_mem,
  input  logic              in_write,
  input  logic [BE_W-1:0]   in_be,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-1:1] lat_addr,
  output logic              lat_mem,
  output logic              lat_write,
  output logic [BE_W-1:0]   lat_be,
  output logic [DATA_W-1:0] lat_wdata,
  output logic [DATA_W-1:0] rdata
);
  // request holding register, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr  <= '0;
      lat_mem   <= 1'b0;
      lat_write <= 1'b0;
      lat_be    <= '0;
      lat_wdata <= '0;
    end else if (load_en) begin
      lat_addr  <= in_addr;
      lat_mem   <= in_mem;
      lat_write <= in_write;
      lat_be    <= in_be;
      lat_wdata <= in_wdata;
    end
  end

  // read capture register, enabled at the end of T3 of a read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= ad_in;
  end
endmodule

// File: rtl/bus_seq_pins.sv
module bus_seq_pins
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  bus_state_e        state,
  input  logic [ADDR_W-1:1] lat_addr,
  input  logic              lat_mem,
  input  logic              lat_write,
  input  logic [BE_W-1:0]   lat_be,
  input  logic [DATA_W-1:0] lat_wdata,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   a_hi,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m_io,
  output logic              dt_r,
  output logic              den_n,
  output logic              bhe_n,
  output logic              done,
  output logic              req_ready
);
  logic [HI_W-1:0] status;

  always_comb begin
    status    = '0;
    status[1] = lat_mem;
    status[0] = lat_write;
  end

  always_comb begin
    ad_out    = '0;
    ad_oe     = 1'b0;
    a_hi      = '0;
    ale       = 1'b0;
    rd_n      = 1'b1;
    wr_n      = 1'b1;
    m_io      = 1'b0;
    dt_r      = 1'b1;
    den_n     = 1'b1;
    bhe_n     = 1'b1;
    done      = 1'b0;
    req_ready = 1'b0;
    case (state)
      ST_IDLE: req_ready = 1'b1;
      ST_T1: begin
        ale    = 1'b1;
        ad_oe  = 1'b1;
        ad_out = {lat_addr[DATA_W-1:1], ~lat_be[0]};
        a_hi   = lat_addr[ADDR_W-1:DATA_W];
        m_io   = lat_mem;
        dt_r   = lat_write;
        bhe_n  = ~lat_be[BE_W-1];
      end
      ST_T2, ST_TW, ST_T3: begin
        rd_n   = lat_write;
        wr_n   = ~lat_write;
        den_n  = 1'b0;
        ad_oe  = lat_write;
        ad_out = lat_wdata;
        a_hi   = status;
        m_io   = lat_mem;
        dt_r   = lat_write;
        bhe_n  = ~lat_be[BE_W-1];
      end
      ST_T4: begin
        a_hi   = status;
        m_io   = lat_mem;
        dt_r   = lat_write;
        bhe_n  = ~lat_be[BE_W-1];
        done   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:1] req_addr,
  input  logic              req_mem,
  input  logic              req_write,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ready_in,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   a_hi,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              m_io,
  output logic              dt_r,
  output logic              den_n,
  output logic              bhe_n,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  bus_state_e        state;
  logic              accept;
  logic              cap_en;
  logic [ADDR_W-1:1] lat_addr;
  logic              lat_mem;
  logic              lat_write;
  logic [BE_W-1:0]   lat_be;
  logic [DATA_W-1:0] lat_wdata;

  assign cap_en = (state == ST_T3) && !lat_write;

  bus_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ready_in  (ready_in),
    .state     (state),
    .accept    (accept)
  );

  bus_seq_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (accept),
    .cap_en    (cap_en),
    .in_addr   (req_addr),
    .in_mem    (req_mem),
    .in_write  (req_write),
    .in_be     (req_be),
    .in_wdata  (req_wdata),
    .ad_in     (ad_in),
    .lat_addr  (lat_addr),
    .lat_mem   (lat_mem),
    .lat_write (lat_write),
    .lat_be    (lat_be),
    .lat_wdata (lat_wdata),
    .rdata     (rdata)
  );

  bus_seq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state     (state),
    .lat_addr  (lat_addr),
    .lat_mem   (lat_mem),
    .lat_write (lat_write),
    .lat_be    (lat_be),
    .lat_wdata (lat_wdata),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .a_hi      (a_hi),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .m_io      (m_io),
    .dt_r      (dt_r),
    .den_n     (den_n),
    .bhe_n     (bhe_n),
    .done      (done),
    .req_ready (req_ready)
  );
endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ready_in,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic den_n,
  input logic ad_oe,
  input logic bhe_n,
  input logic done
);
  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (ale && !req_ready));

  assert_ale_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && rd_n && wr_n && den_n));

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_read_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  assert_t2_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!den_n && !ale));

  assert_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!den_n && !ready_in && $past(ale)) |=> (!den_n && !done));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n && wr_n && den_n && !ad_oe));

  assert_bhe_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !ale) |-> $stable(bhe_n));
endmodule

bind mux_bus_seq bus_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ready_in  (ready_in),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .den_n     (den_n),
  .ad_oe     (ad_oe),
  .bhe_n     (bhe_n),
  .done      (done)
);

// File: tb/tb_mux_bus_seq.sv
module tb_mux_bus_seq;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [19:1] req_addr;
  logic        req_mem;
  logic        req_write;
  logic [1:0]  req_be;
  logic [15:0] req_wdata;
  logic        ready_in;
  logic [15:0] ad_in;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [3:0]  a_hi;
  logic        ale, rd_n, wr_n, m_io, dt_r, den_n, bhe_n, done;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  mux_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mem(req_mem), .req_write(req_write),
    .req_be(req_be), .req_wdata(req_wdata), .ready_in(ready_in),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io), .dt_r(dt_r),
    .den_n(den_n), .bhe_n(bhe_n), .done(done), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // control vector order: ale rd_n wr_n den_n ad_oe m_io dt_r bhe_n done req_ready
  function automatic logic [9:0] ctl_now();
    return {ale, rd_n, wr_n, den_n, ad_oe, m_io, dt_r, bhe_n, done, req_ready};
  endfunction

  task automatic chk_idle(input string tag);
    chk({tag, " idle controls"}, {22'd0, ctl_now()}, {22'd0, 10'b0_1_1_1_0_0_1_1_0_1});
    chk({tag, " idle a_hi"}, {28'd0, a_hi}, 32'd0);
  endtask

  // Reference timeline for one transfer; called at a falling edge while idle.
  task automatic xfer(input logic [19:1] a, input bit mem, input bit wr,
                      input logic [1:0] be, input logic [15:0] wd,
                      input int nw, input logic [15:0] rv, input bit decoy);
    logic [3:0] stat;
    logic [9:0] mid;
    stat = {2'b00, mem, wr};
    mid  = {1'b0, wr, ~wr, 1'b0, wr, mem, wr, ~be[1], 1'b0, 1'b0};
    chk("R1 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = a; req_mem = mem; req_write = wr;
    req_be = be; req_wdata = wd; ad_in = 16'hDEAD;
    @(posedge clk); @(negedge clk);
    // T1
    if (decoy) begin
      req_addr = ~a; req_mem = ~mem; req_write = ~wr; req_be = ~be | 2'b01; req_wdata = ~wd;
    end else req_valid = 1'b0;
    ready_in = (nw != 0); // value in T1 must not matter (R4)
    chk("R2 T1 controls", {22'd0, ctl_now()}, {22'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, mem, wr, ~be[1], 1'b0, 1'b0});
    chk("R2 R7 T1 ad_out", {16'd0, ad_out}, {16'd0, a[15:1], ~be[0]});
    chk("R2 T1 a_hi", {28'd0, a_hi}, {28'd0, a[19:16]});
    @(posedge clk); @(negedge clk);
    // T2
    chk("R3 R9 T2 controls", {22'd0, ctl_now()}, {22'd0, mid});
    chk("R6 T2 status", {28'd0, a_hi}, {28'd0, stat});
    if (wr) chk("R3 T2 write data", {16'd0, ad_out}, {16'd0, wd});
    ready_in = (nw == 0);
    @(posedge clk); @(negedge clk);
    for (int i = 1; i <= nw; i++) begin
      chk("R4 wait state controls", {22'd0, ctl_now()}, {22'd0, mid});
      ready_in = (i == nw);
      @(posedge clk); @(negedge clk);
    end
    // T3
    chk("R3 T3 controls", {22'd0, ctl_now()}, {22'd0, mid});
    ad_in = rv;
    ready_in = 1'b0; // ignored in T3 (R4)
    @(posedge clk); @(negedge clk);
    // T4
    ad_in = 16'hBEEF;
    req_valid = 1'b0;
    chk("R5 R8 T4 controls", {22'd0, ctl_now()}, {22'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, mem, wr, ~be[1], 1'b1, 1'b0});
    chk("R6 T4 status", {28'd0, a_hi}, {28'd0, stat});
    if (!wr) chk("R5 read data", {16'd0, rdata}, {16'd0, rv});
    @(posedge clk); @(negedge clk);
    chk_idle("R8 R11 after T4");
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_mem = 1'b0;
    req_write = 1'b0; req_be = 2'b11; req_wdata = '0; ready_in = 1'b1; ad_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R10 R11 in reset");
    chk("R5 rdata reset", {16'd0, rdata}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R11 after reset");

    xfer(19'h4_1234, 1'b1, 1'b0, 2'b11, 16'h0000, 0, 16'hA5C3, 1'b0);
    xfer(19'h0_0040, 1'b0, 1'b1, 2'b01, 16'h1357, 0, 16'h0000, 1'b0);
    xfer(19'h7_FFFF, 1'b1, 1'b0, 2'b10, 16'h0000, 2, 16'h5AA5, 1'b0);
    xfer(19'h2_0F0F, 1'b1, 1'b1, 2'b11, 16'hC0DE, 3, 16'h0000, 1'b1);
    xfer(19'h1_8001, 1'b0, 1'b0, 2'b01, 16'h0000, 1, 16'h8001, 1'b1);

    for (int k = 0; k < 24; k++) begin
      logic [19:1] ka;
      ka = 19'(k * 24593 + 77);
      xfer(ka, k[0], k[1], 2'((k % 3) + 1), 16'(k * 4099), k % 5, 16'(k * 7919 + 3), k[2]);
    end

    // R10: reset in the middle of a cycle
    req_valid = 1'b1; req_addr = 19'h3_3333; req_mem = 1'b1; req_write = 1'b1;
    req_be = 2'b11; req_wdata = 16'h7777; ready_in = 1'b0;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 strobe active before reset", {31'd0, wr_n}, 32'd0);
    rst_n = 1'b0;
    #1;
    chk_idle("R10 async reset mid-cycle");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R10 idle after release");
    xfer(19'h5_0505, 1'b1, 1'b0, 2'b11, 16'h0000, 1, 16'h0BAD, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule